// File: doc/BRIEF.md
# I2C Multi-Address Slave Matcher

This block sits behind the byte shifter of an I2C slave controller. It sees every address byte that follows a START or repeated START and decides, one clock later, whether the controller should acknowledge. Four 7-bit address entries and one 10-bit entry can be configured. Each entry has its own mask and its own general-call enable.

A decision is one `dec_valid_o` pulse. With it come `ack_o`, the index of the matching entry, a general-call flag and the read/write direction. These outputs hold their values until the next decision. In 10-bit addressing the first byte (prefix `11110`, address bits 9:8, R/W) gets no decision if its upper bits match. The decision comes after the second byte, which carries address bits 7:0. Once a decision is made, later bytes are ignored until the next START.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset `dec_valid_o`, `ack_o`, `gc_o`, `rw_o` are 0 and `match_idx_o` is 0.
- R2: The first address byte after `start_i` carries a 7-bit address in bits 7:1. It matches entry i when `en7_i` is set and the address equals `sadr_i[8i+7:8i+1]` on every bit where `mask_i[8i+7:8i+1]` is 0 (mask bit 1 = don't care). The decision pulse comes in the cycle after the byte is accepted. It reports `ack_o` = `ack_en_i` AND (any entry matched), and `match_idx_o` = the matched entry, or 0 when nothing matched.
- R3: When several 7-bit entries match, `match_idx_o` is the lowest-numbered one.
- R4: With `en7_i` clear, no 7-bit entry matches and the decision is a NACK.
- R5: With `ack_en_i` clear, every decision has `ack_o` = 0.
- R6: A first byte of 0x00 is a general call. It reports `gc_o` = 1, `match_idx_o` = 0 and `rw_o` = 0. `ack_o` = `ack_en_i` AND (some 7-bit entry has its bit 0 set while `en7_i` is set, or `xsadr_i[0]` is set while `en10_i` is set). For all other decisions `gc_o` = 0.
- R7: With `en10_i` set, a first byte of the form 11110 a9 a8 rw whose a9:a8 match `xsadr_i[10:9]` under `xmask_i[10:9]` produces no decision. The next byte is then compared with `xsadr_i[8:1]` under `xmask_i[8:1]`. Its decision reports `match_idx_o` = 4 (number of 7-bit entries).
- R8: A 10-bit first byte whose a9:a8 mismatch gives an immediate NACK decision, with `match_idx_o` = 4.
- R9: With `en10_i` clear, a byte with the 11110 prefix is matched as a 7-bit address.
- R10: Bytes that arrive after a decision and before the next `start_i` produce no decision.
- R11: `start_i` restarts the address phase and abandons a pending 10-bit second byte.
- R12: `rw_o` is bit 0 of the first address byte, in both 7-bit and 10-bit addressing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START or repeated START seen |
| byte_valid_i | input | 1 | A received byte is on byte_i |
| byte_i | input | 8 | Received byte |
| en7_i | input | 1 | Enable 7-bit matching |
| en10_i | input | 1 | Enable 10-bit matching |
| ack_en_i | input | 1 | Acknowledge enable |
| sadr_i | input | 32 | Per entry: address in bits 7:1, general-call enable in bit 0 |
| mask_i | input | 32 | Per entry: don't-care mask in bits 7:1 |
| xsadr_i | input | 11 | 10-bit address in bits 10:1, general-call enable in bit 0 |
| xmask_i | input | 11 | 10-bit mask in bits 10:1 |
| dec_valid_o | output | 1 | Decision pulse |
| ack_o | output | 1 | Acknowledge the address |
| match_idx_o | output | 3 | Matched entry, 4 for the 10-bit entry |
| gc_o | output | 1 | General call decided |
| rw_o | output | 1 | Direction bit of the transfer |

## Verification
The state that is hardest to reach is a 10-bit transfer in mid-flight. The pending second byte exists only after a prefix byte whose upper bits match. The stimulus reaches it with a START and a matching prefix byte. It then checks that no decision appears, and either completes the pair or cuts it off with a new START followed by a 7-bit byte. A second awkward case is a prefix byte with 10-bit matching disabled, which must fall through to an ordinary 7-bit entry.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_FIRST, PH_SECOND} phase_e;
  localparam logic [4:0] TEN_PREFIX = 5'b11110;
  localparam logic [7:0] GC_BYTE    = 8'h00;
  localparam int unsigned ENTRY_W   = 8;
endpackage

// File: rtl/i2c_am_cmp7.sv
module i2c_am_cmp7 #(
  parameter int unsigned NUM = 4,
  localparam int unsigned VW = NUM * i2c_am_pkg::ENTRY_W
) (
  input  logic [VW-1:0]  sadr_i,
  input  logic [VW-1:0]  mask_i,
  input  logic [6:0]     addr_i,
  input  logic           en_i,
  output logic [NUM-1:0] hit_o,
  output logic           gc_any_o
);
  logic [NUM-1:0] gc_vec;

  for (genvar g = 0; g < NUM; g++) begin : g_ent
    logic [6:0] a, m;
    assign a = sadr_i[g*8+7 -: 7];
    assign m = mask_i[g*8+7 -: 7];
    assign hit_o[g]  = en_i & (((a ^ addr_i) & ~m) == 7'd0);
    assign gc_vec[g] = sadr_i[g*8];
  end

  assign gc_any_o = en_i & (|gc_vec);
endmodule

// File: rtl/i2c_am_prio.sv
module i2c_am_prio #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0] hit_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = W'(i);
    end
  end
  assign any_o = |hit_i;
endmodule

// File: rtl/i2c_am_cmp10.sv
module i2c_am_cmp10 (
  input  logic [10:0] xsadr_i,
  input  logic [10:0] xmask_i,
  input  logic [1:0]  hi_i,
  input  logic [7:0]  lo_i,
  input  logic        en_i,
  output logic        hi_hit_o,
  output logic        lo_hit_o,
  output logic        gc_o
);
  assign hi_hit_o = en_i & (((xsadr_i[10:9] ^ hi_i) & ~xmask_i[10:9]) == 2'd0);
  assign lo_hit_o = ((xsadr_i[8:1] ^ lo_i) & ~xmask_i[8:1]) == 8'd0;
  assign gc_o     = en_i & xsadr_i[0];
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int unsigned NUM7 = 4,
  localparam int unsigned IDX_W = $clog2(NUM7 + 1),
  localparam int unsigned VW = NUM7 * ENTRY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  input  logic             en7_i,
  input  logic             en10_i,
  input  logic             ack_en_i,
  input  logic [VW-1:0]    sadr_i,
  input  logic [VW-1:0]    mask_i,
  input  logic [10:0]      xsadr_i,
  input  logic [10:0]      xmask_i,
  output logic             dec_valid_o,
  output logic             ack_o,
  output logic [IDX_W-1:0] match_idx_o,
  output logic             gc_o,
  output logic             rw_o
);
  localparam logic [IDX_W-1:0] TEN_IDX = IDX_W'(NUM7);

  phase_e ph_q, ph_d;
  logic   rw_pend_q, rw_pend_d;
  logic   dec_d, ack_d, gc_d, rw_d;
  logic [IDX_W-1:0] idx_d;

  logic [NUM7-1:0]  hit7;
  logic             gc7, any7, hi_hit, lo_hit, gc10;
  logic [IDX_W-1:0] idx7;

  i2c_am_cmp7 #(.NUM(NUM7)) u_cmp7 (
    .sadr_i(sadr_i), .mask_i(mask_i), .addr_i(byte_i[7:1]), .en_i(en7_i),
    .hit_o(hit7), .gc_any_o(gc7)
  );

  i2c_am_prio #(.N(NUM7), .W(IDX_W)) u_prio (
    .hit_i(hit7), .any_o(any7), .idx_o(idx7)
  );

  i2c_am_cmp10 u_cmp10 (
    .xsadr_i(xsadr_i), .xmask_i(xmask_i), .hi_i(byte_i[2:1]), .lo_i(byte_i),
    .en_i(en10_i), .hi_hit_o(hi_hit), .lo_hit_o(lo_hit), .gc_o(gc10)
  );

  logic is_gc, is_ten;
  assign is_gc  = (byte_i == GC_BYTE);
  assign is_ten = en10_i & (byte_i[7:3] == TEN_PREFIX);

  always_comb begin
    ph_d      = ph_q;
    rw_pend_d = rw_pend_q;
    dec_d     = 1'b0;
    ack_d     = ack_o;
    gc_d      = gc_o;
    rw_d      = rw_o;
    idx_d     = match_idx_o;
    if (start_i) begin
      ph_d = PH_FIRST;
    end else if (byte_valid_i) begin
      unique case (ph_q)
        PH_FIRST: begin
          if (is_gc) begin
            dec_d = 1'b1;
            ack_d = ack_en_i & (gc7 | gc10);
            gc_d  = 1'b1;
            idx_d = '0;
            rw_d  = 1'b0;
            ph_d  = PH_IDLE;
          end else if (is_ten && hi_hit) begin
            rw_pend_d = byte_i[0];
            ph_d      = PH_SECOND;
          end else if (is_ten) begin
            dec_d = 1'b1;
            ack_d = 1'b0;
            gc_d  = 1'b0;
            idx_d = TEN_IDX;
            rw_d  = byte_i[0];
            ph_d  = PH_IDLE;
          end else begin
            dec_d = 1'b1;
            ack_d = ack_en_i & any7;
            gc_d  = 1'b0;
            idx_d = any7 ? idx7 : '0;
            rw_d  = byte_i[0];
            ph_d  = PH_IDLE;
          end
        end
        PH_SECOND: begin
          dec_d = 1'b1;
          ack_d = ack_en_i & lo_hit;
          gc_d  = 1'b0;
          idx_d = TEN_IDX;
          rw_d  = rw_pend_q;
          ph_d  = PH_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q        <= PH_IDLE;
      rw_pend_q   <= 1'b0;
      dec_valid_o <= 1'b0;
      ack_o       <= 1'b0;
      gc_o        <= 1'b0;
      rw_o        <= 1'b0;
      match_idx_o <= '0;
    end else begin
      ph_q        <= ph_d;
      rw_pend_q   <= rw_pend_d;
      dec_valid_o <= dec_d;
      ack_o       <= ack_d;
      gc_o        <= gc_d;
      rw_o        <= rw_d;
      match_idx_o <= idx_d;
    end
  end

  assert_ack_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && ack_o) |-> $past(ack_en_i));

  assert_gc_fields_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && gc_o) |-> (match_idx_o == '0 && !rw_o));

  assert_second_byte_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SECOND && byte_valid_i && !start_i) |=> (dec_valid_o && match_idx_o == TEN_IDX));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_IDLE || start_i || !byte_valid_i) |=> !dec_valid_o);

  assert_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (ph_q == PH_FIRST));
endmodule

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, byte_valid_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic en7_i = 1'b1, en10_i = 1'b1, ack_en_i = 1'b1;
  logic [31:0] sadr_i, mask_i;
  logic [10:0] xsadr_i, xmask_i;
  logic dec_valid_o, ack_o, gc_o, rw_o;
  logic [2:0] match_idx_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  // entries: 0x50 exact; 0x20 low4 don't care + gc; 0x23 exact; 0x7A exact
  assign sadr_i  = {7'h7A, 1'b0, 7'h23, 1'b0, 7'h20, 1'b1, 7'h50, 1'b0};
  assign mask_i  = {7'h00, 1'b0, 7'h00, 1'b0, 7'h0F, 1'b0, 7'h00, 1'b0};
  assign xsadr_i = {10'h2A5, 1'b0};
  assign xmask_i = {10'h00F, 1'b0};

  i2c_addr_match dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .byte_valid_i(byte_valid_i),
    .byte_i(byte_i), .en7_i(en7_i), .en10_i(en10_i), .ack_en_i(ack_en_i),
    .sadr_i(sadr_i), .mask_i(mask_i), .xsadr_i(xsadr_i), .xmask_i(xmask_i),
    .dec_valid_o(dec_valid_o), .ack_o(ack_o), .match_idx_o(match_idx_o),
    .gc_o(gc_o), .rw_o(rw_o)
  );

  typedef struct packed {
    logic [7:0] b1; logic two; logic [7:0] b2;
    logic en7; logic en10; logic acken;
    logic ack; logic [2:0] idx; logic gc; logic rw;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'hA0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0}, // R2
    '{8'hA1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, 1'b1}, // R12
    '{8'h55, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 3'd1, 1'b0, 1'b1}, // R2 mask
    '{8'h46, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 3'd1, 1'b0, 1'b0}, // R3
    '{8'hF4, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 3'd3, 1'b0, 1'b0}, // R9
    '{8'hA0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0}, // R4
    '{8'hA0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0}, // R5
    '{8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 1'b1, 1'b0}, // R6
    '{8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0}, // R6
    '{8'hF4, 1'b1, 8'hA5, 1'b1, 1'b1, 1'b1, 1'b1, 3'd4, 1'b0, 1'b0}, // R7
    '{8'hF4, 1'b1, 8'hAC, 1'b1, 1'b1, 1'b1, 1'b1, 3'd4, 1'b0, 1'b0}, // R7 mask
    '{8'hF4, 1'b1, 8'hB5, 1'b1, 1'b1, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0}, // R7 miss
    '{8'hF6, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0}, // R8
    '{8'hF5, 1'b1, 8'hA5, 1'b1, 1'b1, 1'b1, 1'b1, 3'd4, 1'b0, 1'b1}, // R12
    '{8'hF4, 1'b1, 8'hA5, 1'b1, 1'b1, 1'b0, 1'b0, 3'd4, 1'b0, 1'b0}, // R5
    '{8'h60, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0}  // R2 miss
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send_start();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask

  // drives a byte for one cycle; returns at the negedge after the capturing edge
  task automatic send_byte(input logic [7:0] b);
    @(negedge clk_i) begin byte_valid_i = 1'b1; byte_i = b; end
    @(negedge clk_i) byte_valid_i = 1'b0;
  endtask

  task automatic chk_dec(input string req, input logic ack, input logic [2:0] idx,
                         input logic gc, input logic rw);
    chk(req, {28'd0, dec_valid_o, ack_o, gc_o, rw_o}, {28'd0, 1'b1, ack, gc, rw});
    chk(req, {29'd0, match_idx_o}, {29'd0, idx});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", {27'd0, dec_valid_o, ack_o, gc_o, rw_o, match_idx_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", {27'd0, dec_valid_o, ack_o, gc_o, rw_o, match_idx_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      en7_i = VECS[i].en7; en10_i = VECS[i].en10; ack_en_i = VECS[i].acken;
      send_start();
      send_byte(VECS[i].b1);
      if (VECS[i].two) begin
        chk($sformatf("R7 first byte quiet v%0d", i), {31'd0, dec_valid_o}, 32'd0);
        send_byte(VECS[i].b2);
      end
      chk_dec($sformatf("vec%0d", i), VECS[i].ack, VECS[i].idx, VECS[i].gc, VECS[i].rw);
    end

    en7_i = 1'b1; en10_i = 1'b1; ack_en_i = 1'b1;

    // R10: bytes after a decision are ignored
    send_start();
    send_byte(8'hA0);
    chk_dec("R10 setup", 1'b1, 3'd0, 1'b0, 1'b0);
    send_byte(8'hA0);
    chk("R10", {31'd0, dec_valid_o}, 32'd0);
    send_byte(8'h00);
    chk("R10", {31'd0, dec_valid_o}, 32'd0);

    // R11: restart drops a pending 10-bit second byte
    send_start();
    send_byte(8'hF4);
    chk("R11 pending", {31'd0, dec_valid_o}, 32'd0);
    send_start();
    send_byte(8'hA1);
    chk_dec("R11", 1'b1, 3'd0, 1'b0, 1'b1);

    // R10: outputs hold after the decision pulse
    @(negedge clk_i);
    chk("R10 hold", {27'd0, dec_valid_o, ack_o, gc_o, rw_o, match_idx_o},
        {27'd0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd0});

    finish_run();
  end
endmodule